// File: doc/BRIEF.md
# Wake-on-Receive Duty-Cycle Timer

This block lets a radio save power by cycling, with no host involvement, between a sleep phase with the receiver off and a short listening phase with the receiver on. It runs from a slow tick of about 4 kHz, given as a one-clock enable pulse in the system clock domain. Two programmed durations set the cycle. A 6-bit listen length counts raw slow ticks. A 10-bit sleep length counts through a divide-by-32 prescaler. Each duration is its setting plus one.

The sleep length is loaded as two separately written bytes: a low byte and a 2-bit upper part. When the receiver flags a valid packet during a listening phase, the timer leaves the cycle. It keeps the receiver on and holds a wake interrupt until the host acknowledges it. Clearing the enable input stops everything at once and returns the timer to idle with its counters cleared.

Top module: `wor_duty_timer`

## Requirements
- R1: After reset the timer is idle: `phase_rx_o`, `rx_en_pulse_o` and `wake_irq_o` are all 0, and the stored sleep length is 0.
- R2: In the first clock after `enable_i` rises, the timer enters the sleep phase, so `phase_rx_o` stays 0. The sleep counter and the prescaler are loaded from the current settings.
- R3: A sleep phase entered at the end of a listen phase lasts exactly (S+1)×32 slow ticks, where S is the 10-bit sleep length.
- R4: A listen phase lasts exactly (A+1) slow ticks, where A is `act_len_i`. `phase_rx_o` is 1 throughout it.
- R5: `rx_en_pulse_o` is high for exactly one clock, in the first cycle of each listen phase, and at no other time.
- R6: A write with `slp_lo_we_i` replaces bits 7:0 of S with `slp_lo_i`. A write with `slp_hi_we_i` replaces bits 9:8 of S with `slp_hi_i`. Neither write changes the other bits.
- R7: While enabled and with no packet, sleep and listen phases alternate without end.
- R8: If `pkt_valid_i` is high in any clock of a listen phase, the timer enters a hold state in which `phase_rx_o`=1 and `wake_irq_o`=1. It stays there until `wake_clr_i` is high for a clock, after which it re-enters a sleep phase.
- R9: `pkt_valid_i` has no effect during a sleep phase.
- R10: If `pkt_valid_i` arrives in the same clock as the slow tick that would end a listen phase, the packet wins and the timer enters hold.
- R11: When `enable_i` is 0, the timer is idle from the next clock on, from any state. Its counters are cleared and `wake_irq_o` is 0. A later enable starts a full sleep phase.
- R12: A change to A or S during a phase does not alter that phase. The new value is used from the next phase that loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick_i | input | 1 | One-clock pulse per slow-clock period (~4 kHz) |
| enable_i | input | 1 | Runs the duty cycle when 1; idle when 0 |
| act_len_i | input | 6 | Listen length setting A (phase lasts A+1 ticks) |
| slp_lo_we_i | input | 1 | Write strobe for the low byte of S |
| slp_lo_i | input | 8 | Low byte of S |
| slp_hi_we_i | input | 1 | Write strobe for the upper bits of S |
| slp_hi_i | input | 2 | Bits 9:8 of S |
| pkt_valid_i | input | 1 | Valid-packet flag from the receiver |
| wake_clr_i | input | 1 | Acknowledges the wake interrupt and resumes cycling |
| phase_rx_o | output | 1 | 1 while listening or holding, 0 while sleeping or idle |
| rx_en_pulse_o | output | 1 | One-clock strobe at the start of each listen phase |
| wake_irq_o | output | 1 | Wake interrupt, held while in the hold state |

## Verification
Two events can fall in the same clock: a packet flag, and the slow tick that finishes a listen phase. The bench provokes this with a listen length of zero, so the listen phase ends on its very next tick. It then raises `pkt_valid_i` exactly in the clock where `slow_tick_i` is high. The outcome is judged at the ports: the wake interrupt must be set and the receiver must remain on, rather than the timer dropping back to sleep. A behavioural reference model, which counts the remaining ticks of each phase, is compared with every output on every clock. This catches any off-by-one error at the phase boundaries.

// File: rtl/wor_pkg.sv
package wor_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SLEEP  = 2'd1,
        PH_LISTEN = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;
endpackage

// File: rtl/wor_sleep_reg.sv
module wor_sleep_reg #(
    parameter int SLP_W = 10,
    parameter int LO_W  = 8,
    localparam int HI_W = SLP_W - LO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_we_i,
    input  logic [LO_W-1:0]  lo_i,
    input  logic             hi_we_i,
    input  logic [HI_W-1:0]  hi_i,
    output logic [SLP_W-1:0] slp_o
);
    logic [SLP_W-1:0] slp_d, slp_q;

    always_comb begin
        slp_d = slp_q;
        if (lo_we_i) slp_d[LO_W-1:0]     = lo_i;
        if (hi_we_i) slp_d[SLP_W-1:LO_W] = hi_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slp_q <= '0;
        else        slp_q <= slp_d;
    end

    assign slp_o = slp_q;

    // R6
    hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_we_i && !lo_we_i) |=> (slp_q[LO_W-1:0] == $past(slp_q[LO_W-1:0])));

    // R6
    lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we_i && !hi_we_i) |=> (slp_q[SLP_W-1:LO_W] == $past(slp_q[SLP_W-1:LO_W])));
endmodule

// File: rtl/wor_phase_ctrl.sv
module wor_phase_ctrl
    import wor_pkg::*;
#(
    parameter int ACT_W   = 6,
    parameter int SLP_W   = 10,
    parameter int PRE_DIV = 32,
    localparam int CNT_W  = (ACT_W > SLP_W) ? ACT_W : SLP_W,
    localparam int PRE_W  = $clog2(PRE_DIV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             enable_i,
    input  logic [ACT_W-1:0] act_len_i,
    input  logic [SLP_W-1:0] slp_len_i,
    input  logic             pkt_valid_i,
    input  logic             wake_clr_i,
    output logic             phase_rx_o,
    output logic             rx_en_pulse_o,
    output logic             wake_irq_o
);
    localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(PRE_DIV - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [PRE_W-1:0] pre;
        logic             pulse;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.pulse = 1'b0;
        if (!enable_i) begin
            r_d.ph  = PH_IDLE;
            r_d.cnt = '0;
            r_d.pre = '0;
        end else begin
            unique case (r_q.ph)
                PH_IDLE: begin
                    r_d.ph  = PH_SLEEP;
                    r_d.cnt = CNT_W'(slp_len_i);
                    r_d.pre = PRE_MAX;
                end
                PH_SLEEP: begin
                    if (tick_i) begin
                        if (r_q.pre != '0) begin
                            r_d.pre = r_q.pre - 1'b1;
                        end else if (r_q.cnt != '0) begin
                            r_d.cnt = r_q.cnt - 1'b1;
                            r_d.pre = PRE_MAX;
                        end else begin
                            r_d.ph    = PH_LISTEN;
                            r_d.cnt   = CNT_W'(act_len_i);
                            r_d.pulse = 1'b1;
                        end
                    end
                end
                PH_LISTEN: begin
                    if (pkt_valid_i) begin
                        r_d.ph  = PH_HOLD;
                        r_d.cnt = '0;
                    end else if (tick_i) begin
                        if (r_q.cnt != '0) begin
                            r_d.cnt = r_q.cnt - 1'b1;
                        end else begin
                            r_d.ph  = PH_SLEEP;
                            r_d.cnt = CNT_W'(slp_len_i);
                            r_d.pre = PRE_MAX;
                        end
                    end
                end
                PH_HOLD: begin
                    if (wake_clr_i) begin
                        r_d.ph  = PH_SLEEP;
                        r_d.cnt = CNT_W'(slp_len_i);
                        r_d.pre = PRE_MAX;
                    end
                end
                default: r_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.ph    <= PH_IDLE;
            r_q.cnt   <= '0;
            r_q.pre   <= '0;
            r_q.pulse <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign phase_rx_o    = (r_q.ph == PH_LISTEN) || (r_q.ph == PH_HOLD);
    assign wake_irq_o    = (r_q.ph == PH_HOLD);
    assign rx_en_pulse_o = r_q.pulse;

    // R5
    rx_pulse_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en_pulse_o |-> ((r_q.ph == PH_LISTEN) && ($past(r_q.ph) == PH_SLEEP)));

    // R11
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> ((r_q.ph == PH_IDLE) && (r_q.cnt == '0) && !wake_irq_o));

    // R8
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.ph == PH_HOLD) && enable_i && !wake_clr_i) |=> wake_irq_o && phase_rx_o);

    // R3
    sleep_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.ph == PH_SLEEP) && enable_i && !tick_i) |=> ($stable(r_q.pre) && $stable(r_q.cnt)));

    // R9
    sleep_pkt_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_SLEEP) |=> !wake_irq_o);
endmodule

// File: rtl/wor_duty_timer.sv
module wor_duty_timer #(
    parameter int ACT_W   = 6,
    parameter int SLP_W   = 10,
    parameter int LO_W    = 8,
    parameter int PRE_DIV = 32,
    localparam int HI_W   = SLP_W - LO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick_i,
    input  logic             enable_i,
    input  logic [ACT_W-1:0] act_len_i,
    input  logic             slp_lo_we_i,
    input  logic [LO_W-1:0]  slp_lo_i,
    input  logic             slp_hi_we_i,
    input  logic [HI_W-1:0]  slp_hi_i,
    input  logic             pkt_valid_i,
    input  logic             wake_clr_i,
    output logic             phase_rx_o,
    output logic             rx_en_pulse_o,
    output logic             wake_irq_o
);
    logic [SLP_W-1:0] slp_len;

    wor_sleep_reg #(.SLP_W(SLP_W), .LO_W(LO_W)) i_slp_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_we_i (slp_lo_we_i),
        .lo_i    (slp_lo_i),
        .hi_we_i (slp_hi_we_i),
        .hi_i    (slp_hi_i),
        .slp_o   (slp_len)
    );

    wor_phase_ctrl #(.ACT_W(ACT_W), .SLP_W(SLP_W), .PRE_DIV(PRE_DIV)) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (slow_tick_i),
        .enable_i      (enable_i),
        .act_len_i     (act_len_i),
        .slp_len_i     (slp_len),
        .pkt_valid_i   (pkt_valid_i),
        .wake_clr_i    (wake_clr_i),
        .phase_rx_o    (phase_rx_o),
        .rx_en_pulse_o (rx_en_pulse_o),
        .wake_irq_o    (wake_irq_o)
    );
endmodule

// File: tb/test_wor_duty_timer.sv
module test_wor_duty_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       en = 1'b0;
    logic [5:0] act = 6'd0;
    logic       lo_we = 1'b0, hi_we = 1'b0;
    logic [7:0] lo_d = 8'd0;
    logic [1:0] hi_d = 2'd0;
    logic       pkt = 1'b0, wclr = 1'b0;
    logic       phase_rx, rx_pulse, wake_irq;

    int    checks = 0, errors = 0, cyc = 0;
    string cur_req = "R1";

    // behavioural reference: 0 idle, 1 sleep, 2 listen, 3 hold
    int m_ph = 0, m_rem = 0, m_slp = 0, m_pulse = 0;

    wor_duty_timer i_wor_duty_timer (
        .clk(clk), .rst_n(rst_n), .slow_tick_i(tick), .enable_i(en),
        .act_len_i(act), .slp_lo_we_i(lo_we), .slp_lo_i(lo_d),
        .slp_hi_we_i(hi_we), .slp_hi_i(hi_d), .pkt_valid_i(pkt),
        .wake_clr_i(wclr), .phase_rx_o(phase_rx), .rx_en_pulse_o(rx_pulse),
        .wake_irq_o(wake_irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int actv, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, actv, expv, cyc);
        end
    endtask

    // slow tick every fourth clock
    initial begin
        int t = 0;
        forever begin
            @(negedge clk);
            tick = (t % 4 == 3);
            t++;
        end
    end

    always @(posedge clk) begin
        int old;
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_rem = 0; m_slp = 0; m_pulse = 0;
        end else begin
            m_pulse = 0;
            old = m_slp;
            if (!en) m_ph = 0;
            else case (m_ph)
                0: begin m_ph = 1; m_rem = (old + 1) * 32; end
                1: if (tick) begin
                       m_rem--;
                       if (m_rem == 0) begin m_ph = 2; m_rem = int'(act) + 1; m_pulse = 1; end
                   end
                2: if (pkt) m_ph = 3;
                   else if (tick) begin
                       m_rem--;
                       if (m_rem == 0) begin m_ph = 1; m_rem = (old + 1) * 32; end
                   end
                default: if (wclr) begin m_ph = 1; m_rem = (old + 1) * 32; end
            endcase
            if (lo_we) m_slp = (m_slp & 'h300) | int'(lo_d);
            if (hi_we) m_slp = (m_slp & 'h0FF) | (int'(hi_d) << 8);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(phase_rx == (m_ph >= 2), {cur_req, " phase_rx vs model"}, int'(phase_rx), int'(m_ph >= 2));
            chk(wake_irq == (m_ph == 3), {cur_req, " wake_irq vs model"}, int'(wake_irq), int'(m_ph == 3));
            chk(rx_pulse == (m_pulse == 1), {cur_req, " R5 rx pulse vs model"}, int'(rx_pulse), m_pulse);
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic wr_lo(input logic [7:0] v);
        @(negedge clk); #1 lo_we = 1'b1; lo_d = v;
        @(negedge clk); #1 lo_we = 1'b0;
    endtask

    task automatic wr_hi(input logic [1:0] v);
        @(negedge clk); #1 hi_we = 1'b1; hi_d = v;
        @(negedge clk); #1 hi_we = 1'b0;
    endtask

    task automatic measure_low(output int n);
        while (!phase_rx) @(negedge clk);
        while (phase_rx) @(negedge clk);
        n = 0;
        while (!phase_rx) begin n++; @(negedge clk); end
    endtask

    task automatic measure_high(output int n);
        while (phase_rx) @(negedge clk);
        while (!phase_rx) @(negedge clk);
        n = 0;
        while (phase_rx) begin n++; @(negedge clk); end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(!phase_rx && !rx_pulse && !wake_irq, "R1 outputs in reset", int'(phase_rx), 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!phase_rx && !wake_irq, "R1 idle after reset", int'(phase_rx), 0);

        // R2 R3 R4 R7: S=2, A=3
        cur_req = "R2";
        wr_lo(8'd2);
        act = 6'd3;
        #1 en = 1'b1;
        @(negedge clk);
        chk(!phase_rx, "R2 first phase is sleep", int'(phase_rx), 0);
        cur_req = "R3";
        measure_low(n);
        chk(n == 384, "R3 sleep length S=2", n, 384);
        cur_req = "R4";
        measure_high(n);
        chk(n == 16, "R4 listen length A=3", n, 16);
        cur_req = "R7";
        measure_low(n);
        chk(n == 384, "R7 repeated sleep", n, 384);

        // R12: change A in the middle of a listen phase
        cur_req = "R12";
        #1 act = 6'd7;
        n = 0;
        while (phase_rx) begin n++; @(negedge clk); end
        chk(n == 16, "R12 current listen keeps old A", n, 16);
        measure_high(n);
        chk(n == 32, "R12 next listen uses new A", n, 32);
        #1 act = 6'd3;

        // R9: packet during sleep is ignored
        cur_req = "R9";
        repeat (20) @(negedge clk);
        #1 pkt = 1'b1;
        repeat (3) @(negedge clk);
        #1 pkt = 1'b0;
        @(negedge clk);
        chk(!phase_rx && !wake_irq, "R9 packet in sleep ignored", int'(wake_irq), 0);

        // R8: packet during listen
        cur_req = "R8";
        while (!phase_rx) @(negedge clk);
        #1 pkt = 1'b1;
        @(negedge clk); #1 pkt = 1'b0;
        chk(wake_irq && phase_rx, "R8 wake raised", int'(wake_irq), 1);
        repeat (100) @(negedge clk);
        chk(wake_irq && phase_rx, "R8 wake held", int'(wake_irq), 1);
        #1 wclr = 1'b1;
        @(negedge clk); #1 wclr = 1'b0;
        chk(!wake_irq && !phase_rx, "R8 cleared back to sleep", int'(wake_irq), 0);

        // R10: packet on the tick that ends a one-tick listen
        cur_req = "R10";
        #1 act = 6'd0;
        while (!phase_rx) @(negedge clk);
        forever begin
            @(negedge clk); #2;
            if (tick) break;
        end
        pkt = 1'b1;
        @(negedge clk); #1 pkt = 1'b0;
        chk(wake_irq && phase_rx, "R10 packet beats final tick", int'(wake_irq), 1);
        #1 act = 6'd3;

        // R11: disable from hold, then re-enable
        cur_req = "R11";
        repeat (5) @(negedge clk);
        #1 en = 1'b0;
        @(negedge clk);
        chk(!wake_irq && !phase_rx, "R11 disable clears hold", int'(wake_irq), 0);
        repeat (10) @(negedge clk);
        chk(!phase_rx && !rx_pulse, "R11 stays idle", int'(phase_rx), 0);
        #1 en = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!phase_rx);
        chk(n >= 381 && n <= 384, "R11 full sleep after re-enable", n, 384);

        // R6: byte-assembled sleep length
        cur_req = "R6";
        wr_lo(8'd3);
        wr_hi(2'd1);
        measure_low(n);
        chk(n == 33280, "R6 S=0x103", n, 33280);
        wr_hi(2'd0);
        measure_low(n);
        chk(n == 512, "R6 upper write keeps low byte", n, 512);

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule